// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address sequence for one burst of a synchronous DRAM. A small mode register is written by a load strobe. It holds three settings: a burst length code, an order select (counting or interleaved) and a flag that makes writes single-beat. A read or write command carries a start column. From the next clock the block puts out one column per cycle and holds a burst-active flag high until the burst is done.

A burst stops early when a terminate strobe arrives. A new command in any cycle of a running burst drops the old sequence and starts the new one at once; there is no alignment restriction. In full-page mode the sequence counts through the whole page and keeps wrapping until it is terminated or replaced.

The controller is a two-state machine. `ST_IDLE` waits for a command. `ST_BURST` emits beats. The transitions are:
- start: `ST_IDLE` to `ST_BURST` on a command.
- restart: `ST_BURST` to `ST_BURST` on a new command.
- advance: `ST_BURST` to `ST_BURST` on a beat that is neither the last nor terminated.
- finish: `ST_BURST` to `ST_IDLE` on the last beat.
- abort: `ST_BURST` to `ST_IDLE` on terminate.

The burst settings are captured when the command is accepted. A mode load during a burst therefore affects only later commands.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `burst_act`, `beat_last` and `beat_write` are 0 and `col_out` is 0. The mode resets to length 1, counting order, single-write off.
- R2: In the cycle after `cmd_valid` is sampled high, `burst_act` is 1 and `col_out` equals the sampled `cmd_col`.
- R3: With `mode_ilv`=0 and length L of 2, 4 or 8, beat k outputs the start column with its low log2(L) bits replaced by (start+k) mod L. The sequence wraps inside the aligned L-column block.
- R4: With `mode_ilv`=1 and length L, beat k outputs the start column XOR k. Only the low log2(L) bits change.
- R5: Length code 7 with counting order is full page. Beat k is (start+k) mod 2^COL_W, and the burst never ends by itself.
- R6: `beat_last` is 1 exactly on the final beat of a finite burst. `burst_act` is 0 in the cycle after it unless a new command was sampled.
- R7: `cmd_term` sampled high with no command makes `burst_act` 0 in the next cycle. A command in the same cycle takes priority over the terminate.
- R8: A command sampled during a burst restarts the sequence at the new column in the next cycle.
- R9: With `mode_brsw`=1, a write command (`cmd_write`=1) gives exactly one beat and a read uses the programmed length. `beat_write` is 1 during beats of a write burst.
- R10: Length codes are 0→1, 1→2, 2→4, 3→8 and 7→full page. A load with code 4, 5 or 6, or with code 7 and `mode_ilv`=1, leaves the whole mode unchanged.
- R11: A mode load during a burst does not change that burst's length or order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Write mode register this cycle |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = counting order |
| mode_brsw | input | 1 | 1 = writes are single-beat |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | COL_W | Start column of the command |
| cmd_term | input | 1 | Burst terminate strobe |
| col_out | output | COL_W | Column of the current beat (0 when idle) |
| burst_act | output | 1 | A beat is being issued this cycle |
| beat_last | output | 1 | This beat is the last of a finite burst |
| beat_write | output | 1 | Current burst is a write |

## Verification
The bench builds the block with the default COL_W of 8, so a full page is 256 columns. At that size a full-page burst can be run past its wrap point from a start near the top of the page, and every length-8 block, including its wrap, lies within easy reach of directed starts. Starts such as 0x0E and 0x35 place the first column in the middle of an aligned block, so both the counting wrap and the XOR pattern differ visibly from a plain increment.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } state_t;

    typedef struct packed {
        logic [2:0] len;
        logic       ilv;
        logic       brsw;
    } mode_t;

    localparam logic [2:0] LEN_1    = 3'd0;
    localparam logic [2:0] LEN_2    = 3'd1;
    localparam logic [2:0] LEN_4    = 3'd2;
    localparam logic [2:0] LEN_8    = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;

    function automatic logic mode_legal(input logic [2:0] len, input logic ilv);
        logic ok;
        unique case (len)
            LEN_1, LEN_2, LEN_4, LEN_8: ok = 1'b1;
            LEN_PAGE:                   ok = !ilv;
            default:                    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bsq_mode_reg.sv
module bsq_mode_reg
    import bsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] len_in,
    input  logic       ilv_in,
    input  logic       brsw_in,
    output mode_t      mode_q
);

    logic  accept;
    mode_t mode_d;

    always_comb begin
        accept = load && mode_legal(len_in, ilv_in);
        mode_d = mode_q;
        if (accept) begin
            mode_d.len  = len_in;
            mode_d.ilv  = ilv_in;
            mode_d.brsw = brsw_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '{len: LEN_1, ilv: 1'b0, brsw: 1'b0};
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;

    always_comb begin
        sum     = start + beat;
        seq_col = (start & ~mask) | (sum & mask);
        ilv_col = start ^ (beat & mask);
        col     = ilv ? ilv_col : seq_col;
    end

endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
    import bsq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_term,
    output logic [COL_W-1:0] start_q,
    output logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] mask_q,
    output logic             ilv_q,
    output logic             active,
    output logic             last,
    output logic             wr_q
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    state_t           state_q, state_d;
    logic [COL_W-1:0] start_d, beat_d, mask_d, new_mask;
    logic             ilv_d, page_q, page_d, wr_d, new_page, single;

    // burst shape picked from the mode at command time
    always_comb begin
        single   = cmd_write && mode.brsw;
        new_page = 1'b0;
        unique case (mode.len)
            LEN_2:    new_mask = COL_W'(1);
            LEN_4:    new_mask = COL_W'(3);
            LEN_8:    new_mask = COL_W'(7);
            LEN_PAGE: begin
                new_mask = '1;
                new_page = 1'b1;
            end
            default:  new_mask = '0;
        endcase
        if (single) begin
            new_mask = '0;
            new_page = 1'b0;
        end
    end

    always_comb begin
        last = (state_q == ST_BURST) && !page_q && (beat_q == mask_q);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        start_d = start_q;
        beat_d  = beat_q;
        mask_d  = mask_q;
        ilv_d   = ilv_q;
        page_d  = page_q;
        wr_d    = wr_q;
        if (cmd_valid) begin
            // start / restart
            state_d = ST_BURST;
            start_d = cmd_col;
            beat_d  = '0;
            mask_d  = new_mask;
            ilv_d   = mode.ilv;
            page_d  = new_page;
            wr_d    = cmd_write;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_BURST: begin
                    if (cmd_term || last) begin
                        // abort / finish
                        state_d = ST_IDLE;
                        beat_d  = '0;
                    end else begin
                        // advance
                        beat_d = beat_q + ONE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            page_q  <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= start_d;
            beat_q  <= beat_d;
            mask_q  <= mask_d;
            ilv_q   <= ilv_d;
            page_q  <= page_d;
            wr_q    <= wr_d;
        end
    end

    always_comb begin
        active = (state_q == ST_BURST);
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bsq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [2:0]       mode_len,
    input  logic             mode_ilv,
    input  logic             mode_brsw,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_term,
    output logic [COL_W-1:0] col_out,
    output logic             burst_act,
    output logic             beat_last,
    output logic             beat_write
);

    mode_t            mode_q;
    logic [COL_W-1:0] start_q, beat_q, mask_q, gen_col;
    logic             ilv_q, active, last, wr_q;

    bsq_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (mode_load),
        .len_in  (mode_len),
        .ilv_in  (mode_ilv),
        .brsw_in (mode_brsw),
        .mode_q  (mode_q)
    );

    bsq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_col   (cmd_col),
        .cmd_term  (cmd_term),
        .start_q   (start_q),
        .beat_q    (beat_q),
        .mask_q    (mask_q),
        .ilv_q     (ilv_q),
        .active    (active),
        .last      (last),
        .wr_q      (wr_q)
    );

    bsq_addr_gen #(.COL_W(COL_W)) u_gen (
        .start (start_q),
        .beat  (beat_q),
        .mask  (mask_q),
        .ilv   (ilv_q),
        .col   (gen_col)
    );

    // output process
    always_comb begin
        col_out    = active ? gen_col : '0;
        burst_act  = active;
        beat_last  = last;
        beat_write = active && wr_q;
    end

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [COL_W-1:0] cmd_col,
    input logic             cmd_term,
    input logic [COL_W-1:0] col_out,
    input logic             burst_act,
    input logic             beat_last,
    input logic             beat_write
);

    // R2
    cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (burst_act && col_out == $past(cmd_col)));

    // R7
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_term && !cmd_valid) |=> !burst_act);

    // R6
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !cmd_valid) |=> !burst_act);

    // R6
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> burst_act);

    // R5
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && !beat_last && !cmd_term) |=> burst_act);

    // R9
    write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_write |-> burst_act);

endmodule

bind burst_col_seq bsq_checker #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_col    (cmd_col),
    .cmd_term   (cmd_term),
    .col_out    (col_out),
    .burst_act  (burst_act),
    .beat_last  (beat_last),
    .beat_write (beat_write)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_load = 1'b0;
    logic [2:0]       mode_len = '0;
    logic             mode_ilv = 1'b0;
    logic             mode_brsw = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_write = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_term = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             burst_act, beat_last, beat_write;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_len(mode_len),
        .mode_ilv(mode_ilv), .mode_brsw(mode_brsw), .cmd_valid(cmd_valid),
        .cmd_write(cmd_write), .cmd_col(cmd_col), .cmd_term(cmd_term),
        .col_out(col_out), .burst_act(burst_act), .beat_last(beat_last),
        .beat_write(beat_write)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input int k,
                                                 input int len, input logic ilv);
        logic [COL_W-1:0] m, kk;
        m  = COL_W'(len - 1);
        kk = COL_W'(k);
        if (ilv) return s ^ (kk & m);
        return (s & ~m) | ((s + kk) & m);
    endfunction

    task automatic load_mode(input logic [2:0] code, input logic ilv, input logic brsw);
        mode_load = 1'b1; mode_len = code; mode_ilv = ilv; mode_brsw = brsw;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    task automatic issue(input logic [COL_W-1:0] c, input logic wr);
        cmd_valid = 1'b1; cmd_col = c; cmd_write = wr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // full finite burst, beats checked then idle checked
    task automatic run_burst(input logic [COL_W-1:0] s, input logic wr, input int len,
                             input logic ilv, input string req);
        issue(s, wr);
        for (int k = 0; k < len; k++) begin
            chk(burst_act === 1'b1, req, burst_act, 1);
            chk(col_out === exp_col(s, k, len, ilv), req, col_out, exp_col(s, k, len, ilv));
            chk(beat_last === (k == len - 1), {req, "/R6 last"}, beat_last, k == len - 1);
            chk(beat_write === wr, {req, "/R9 wr"}, beat_write, wr);
            @(negedge clk);
        end
        chk(burst_act === 1'b0, "R6 idle after last", burst_act, 0);
    endtask

    task automatic t_reset;
        chk(burst_act === 1'b0 && beat_last === 1'b0 && beat_write === 1'b0, "R1 flags", burst_act, 0);
        chk(col_out === '0, "R1 col", col_out, 0);
        run_burst(8'h5A, 1'b0, 1, 1'b0, "R1 default len");
    endtask

    task automatic t_seq;
        load_mode(3'd2, 1'b0, 1'b0);
        run_burst(8'h0E, 1'b0, 4, 1'b0, "R3 seq4");
        load_mode(3'd3, 1'b0, 1'b0);
        run_burst(8'h35, 1'b0, 8, 1'b0, "R3 seq8");
        load_mode(3'd1, 1'b0, 1'b0);
        run_burst(8'h91, 1'b1, 2, 1'b0, "R3 seq2");
        load_mode(3'd0, 1'b0, 1'b0);
        run_burst(8'hC3, 1'b0, 1, 1'b0, "R2 len1");
    endtask

    task automatic t_ilv;
        load_mode(3'd3, 1'b1, 1'b0);
        run_burst(8'h35, 1'b0, 8, 1'b1, "R4 ilv8");
        load_mode(3'd2, 1'b1, 1'b0);
        run_burst(8'h0D, 1'b1, 4, 1'b1, "R4 ilv4");
    endtask

    task automatic t_page;
        load_mode(3'd7, 1'b0, 1'b0);
        issue(8'hFE, 1'b0);
        for (int k = 0; k < 260; k++) begin
            chk(burst_act === 1'b1 && beat_last === 1'b0, "R5 page active", burst_act, 1);
            chk(col_out === COL_W'(8'hFE + k), "R5 page col", col_out, COL_W'(8'hFE + k));
            if (k == 259) cmd_term = 1'b1;
            @(negedge clk);
        end
        cmd_term = 1'b0;
        chk(burst_act === 1'b0, "R7 term page", burst_act, 0);
    endtask

    task automatic t_term;
        load_mode(3'd3, 1'b0, 1'b0);
        issue(8'h20, 1'b0);
        @(negedge clk);
        cmd_term = 1'b1;
        @(negedge clk);
        cmd_term = 1'b0;
        chk(burst_act === 1'b0 && col_out === '0, "R7 term mid", burst_act, 0);
        // command wins over terminate
        cmd_term = 1'b1;
        issue(8'h44, 1'b0);
        cmd_term = 1'b0;
        chk(burst_act === 1'b1 && col_out === 8'h44, "R7 cmd priority", col_out, 8'h44);
        @(negedge clk);
        chk(col_out === 8'h45, "R7 continues", col_out, 8'h45);
        cmd_term = 1'b1;
        @(negedge clk);
        cmd_term = 1'b0;
    endtask

    task automatic t_restart;
        load_mode(3'd3, 1'b0, 1'b0);
        issue(8'h10, 1'b0);
        @(negedge clk);
        chk(col_out === 8'h11, "R8 before", col_out, 8'h11);
        run_burst(8'h7B, 1'b1, 8, 1'b0, "R8 restart");
    endtask

    task automatic t_brsw;
        load_mode(3'd2, 1'b0, 1'b1);
        run_burst(8'h66, 1'b1, 1, 1'b0, "R9 write single");
        run_burst(8'h66, 1'b0, 4, 1'b0, "R9 read full");
        load_mode(3'd2, 1'b0, 1'b0);
        run_burst(8'h66, 1'b1, 4, 1'b0, "R9 write full when off");
    endtask

    task automatic t_illegal;
        load_mode(3'd3, 1'b1, 1'b0);
        load_mode(3'd5, 1'b0, 1'b1);
        run_burst(8'h35, 1'b1, 8, 1'b1, "R10 code5 ignored");
        load_mode(3'd7, 1'b1, 1'b0);
        run_burst(8'h2A, 1'b0, 8, 1'b1, "R10 page+ilv ignored");
        load_mode(3'd4, 1'b0, 1'b0);
        load_mode(3'd6, 1'b0, 1'b0);
        run_burst(8'h2A, 1'b0, 8, 1'b1, "R10 code4/6 ignored");
    endtask

    task automatic t_midload;
        load_mode(3'd3, 1'b0, 1'b0);
        issue(8'h53, 1'b0);
        mode_load = 1'b1; mode_len = 3'd1; mode_ilv = 1'b1;
        for (int k = 0; k < 8; k++) begin
            chk(col_out === exp_col(8'h53, k, 8, 1'b0), "R11 kept", col_out, exp_col(8'h53, k, 8, 1'b0));
            @(negedge clk);
            mode_load = 1'b0;
        end
        chk(burst_act === 1'b0, "R11 end", burst_act, 0);
        run_burst(8'h53, 1'b0, 2, 1'b1, "R11 new mode later");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_seq;
        t_ilv;
        t_page;
        t_term;
        t_restart;
        t_brsw;
        t_illegal;
        t_midload;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule